// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a single-clock synchronous static RAM that takes a new command on every enabled rising edge and needs no idle cycle when the bus changes direction between reads and writes. Each load edge carries an address, a read or write choice, write data and per-lane write strobes. The chip responds only when all three chip selects are in their active state. Read data is flow-through: it appears combinationally in the cycle that follows the edge that registered the read, with no further output stage.

Writes are not put into the array at once. The write address, data and lane mask are parked in a pending slot. The slot is committed at a later edge that does not carry a read. A read that hits the pending address receives the parked lanes merged over the stored word, so it always sees the newest data. An address-advance input continues the last command through a four-beat burst, in either interleaved or linear order. A clock-enable input and a sleep input freeze all state. The output enable and sleep also gate the data-out enable asynchronously. The bidirectional data bus is modelled as separate data-in, data-out and drive-enable signals.

Top module: `zbt_sram`

## Requirements
- R1: After reset, dout_en is 0, no write is pending, and every array word reads as 0.
- R2: On an enabled edge with adv=0, a command is taken only when ce1_n=0, ce2=1 and ce3_n=0. Otherwise the edge registers a deselect: dout_en is 0 in the following cycle and no array word changes.
- R3: A read registered at an enabled edge (we_n=1) drives dout with the word at that address during the following cycle, with dout_en=1 when oe_n=0 and sleep=0. Whenever dout_en=0, dout is 0.
- R4: Reads and writes may alternate on consecutive edges with no idle cycle. A read always returns the most recently written data for its address, including a write registered on the immediately preceding edge.
- R5: Lane i is bits [8i+7:8i] and is written only when bw_n[i]=0. Lanes with bw_n[i]=1 keep their previous contents.
- R6: A write stays pending across any number of read edges. It is committed at the next enabled edge that carries a write or a deselect, and is never lost.
- R7: An edge with cke_n=1 is ignored. The registered command, burst position, pending write and array are all unchanged, so dout and dout_en keep their values.
- R8: oe_n=1 forces dout_en to 0 in the same cycle without changing internal state. Returning oe_n to 0 restores the read output.
- R9: While sleep=1, dout_en is 0 and edges are ignored as in R7. Stored contents survive, and after sleep returns to 0 the block resumes with its earlier state.
- R10: An enabled edge with adv=1 repeats the previous command type at the next burst address. The upper address bits are those of the loaded address. The low two bits are start^k when lin_mode=0 and (start+k) mod 4 when lin_mode=1, for beat k. The sequence wraps to the start after four beats, and burst writes take din and bw_n on each beat.
- R11: adv=1 after a deselect keeps the block deselected, regardless of the chip selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Load address |
| din | input | LANES*LANE_W | Write data |
| we_n | input | 1 | 0 = write, 1 = read (on load edges) |
| bw_n | input | LANES | Active-low lane write strobes |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| cke_n | input | 1 | Active-low clock enable |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| lin_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Power-down: freeze state and disable output |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | Data bus drive enable |

## Verification
A stale or misplaced pending write shows up on the very next read of that address as a lane mismatch, because forwarding and commit are both tested one cycle after the write edge. A wrong burst counter or order mixup gives the wrong word on the first advanced beat. A hold or sleep leak changes dout, or the contents of a word read back afterwards, within one or two cycles. Deselect and strobe faults appear as corrupted words on the read-back that follows.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

    localparam int BURST_BITS = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e                   op;
        logic [BURST_BITS-1:0] beat;
    } cmd_state_t;

    // Low address bits of a burst beat: interleaved xor or linear add.
    function automatic logic [BURST_BITS-1:0] burst_low(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] beat,
        input logic                  linear
    );
        logic [BURST_BITS-1:0] sum;
        sum = start + beat;
        return linear ? sum : (start ^ beat);
    endfunction

endpackage

// File: rtl/zbt_sram_cmd.sv
module zbt_sram_cmd
    import zbt_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              adv,
    input  logic              sel,
    input  logic              we_n,
    input  logic              lin_mode,
    input  logic [ADDR_W-1:0] addr,
    output op_e               nxt_op,
    output logic [ADDR_W-1:0] nxt_addr,
    output op_e               cur_op,
    output logic [ADDR_W-1:0] cur_addr
);

    cmd_state_t             cur_q, nxt_s;
    logic [ADDR_W-1:0]      base_q, nxt_base;

    always_comb begin
        nxt_base = base_q;
        nxt_s    = '{op: OP_IDLE, beat: '0};
        if (adv) begin
            nxt_s.op   = cur_q.op;
            nxt_s.beat = cur_q.beat + 1'b1;
        end else if (sel) begin
            nxt_s.op = we_n ? OP_READ : OP_WRITE;
            nxt_base = addr;
        end
        nxt_addr = {nxt_base[ADDR_W-1:BURST_BITS],
                    burst_low(nxt_base[BURST_BITS-1:0], nxt_s.beat, lin_mode)};
    end

    assign nxt_op = nxt_s.op;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '{op: OP_IDLE, beat: '0};
            base_q   <= '0;
            cur_addr <= '0;
        end else if (step) begin
            cur_q    <= nxt_s;
            base_q   <= nxt_base;
            cur_addr <= nxt_addr;
        end
    end

    assign cur_op = cur_q.op;

endmodule

// File: rtl/zbt_sram_wbuf.sv
module zbt_sram_wbuf
    import zbt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  op_e               nxt_op,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic [DATA_W-1:0] din,
    input  logic [LANES-1:0]  bw_n,
    output logic              commit,
    output logic              pend_valid,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0] pend_data,
    output logic [LANES-1:0]  pend_be
);

    // A read leaves the slot parked; a write or deselect drains it.
    assign commit = step && pend_valid && (nxt_op != OP_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
            pend_be    <= '0;
        end else if (step) begin
            if (nxt_op == OP_WRITE) begin
                pend_valid <= 1'b1;
                pend_addr  <= nxt_addr;
                pend_data  <= din;
                pend_be    <= ~bw_n;
            end else if (nxt_op == OP_IDLE) begin
                pend_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/zbt_sram_array.sv
module zbt_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              pend_valid,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [DATA_W-1:0] pend_data,
    input  logic [LANES-1:0]  pend_be,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] raw;
    logic              hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (commit) begin
            for (int i = 0; i < LANES; i++)
                if (pend_be[i])
                    mem[pend_addr][i*LANE_W +: LANE_W] <= pend_data[i*LANE_W +: LANE_W];
        end
    end

    assign raw = mem[rd_addr];
    assign hit = pend_valid && (pend_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign rd_word[g*LANE_W +: LANE_W] = (hit && pend_be[g]) ?
            pend_data[g*LANE_W +: LANE_W] : raw[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              cke_n,
    input  logic              adv,
    input  logic              lin_mode,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic              step, sel, commit, pend_valid;
    op_e               nxt_op, cur_op;
    logic [ADDR_W-1:0] nxt_addr, cur_addr, pend_addr;
    logic [DATA_W-1:0] pend_data, rd_word;
    logic [LANES-1:0]  pend_be;

    assign step = !cke_n && !sleep;
    assign sel  = !ce1_n && ce2 && !ce3_n;

    zbt_sram_cmd #(.ADDR_W(ADDR_W)) u_cmd (
        .clk(clk), .rst(rst), .step(step), .adv(adv), .sel(sel),
        .we_n(we_n), .lin_mode(lin_mode), .addr(addr),
        .nxt_op(nxt_op), .nxt_addr(nxt_addr),
        .cur_op(cur_op), .cur_addr(cur_addr)
    );

    zbt_sram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk(clk), .rst(rst), .step(step), .nxt_op(nxt_op),
        .nxt_addr(nxt_addr), .din(din), .bw_n(bw_n), .commit(commit),
        .pend_valid(pend_valid), .pend_addr(pend_addr),
        .pend_data(pend_data), .pend_be(pend_be)
    );

    zbt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .rst(rst), .commit(commit), .pend_valid(pend_valid),
        .pend_addr(pend_addr), .pend_data(pend_data), .pend_be(pend_be),
        .rd_addr(cur_addr), .rd_word(rd_word)
    );

    assign dout_en = (cur_op == OP_READ) && !oe_n && !sleep;
    assign dout    = dout_en ? rd_word : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              we_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              cke_n,
    input logic              adv,
    input logic              oe_n,
    input logic              sleep,
    input logic              dout_en,
    input logic [1:0]        cur_op,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              pend_valid,
    input logic [ADDR_W-1:0] pend_addr
);

    logic go, chosen;
    assign go     = !cke_n && !sleep;
    assign chosen = !ce1_n && ce2 && !ce3_n;

    p_desel_r2: assert property (@(posedge clk) disable iff (rst)
        (go && !adv && !chosen) |=> (cur_op == 2'd0 && !dout_en));

    p_read_load_r3: assert property (@(posedge clk) disable iff (rst)
        (go && !adv && chosen && we_n) |=> (cur_op == 2'd1 && cur_addr == $past(addr)));

    p_pend_load_r6: assert property (@(posedge clk) disable iff (rst)
        (go && !adv && chosen && !we_n) |=> (pend_valid && pend_addr == $past(addr)));

    p_pend_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (go && pend_valid && !adv && chosen && we_n) |=> (pend_valid && $stable(pend_addr)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!go) |=> ($stable(cur_op) && $stable(cur_addr) && $stable(pend_valid) && $stable(pend_addr)));

    p_oe_gate_r8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_en);

    p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dout_en);

    p_burst_upper_r10: assert property (@(posedge clk) disable iff (rst)
        (go && adv) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

    p_adv_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (go && adv && cur_op == 2'd0) |=> (cur_op == 2'd0));

endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .we_n(we_n), .ce1_n(ce1_n),
    .ce2(ce2), .ce3_n(ce3_n), .cke_n(cke_n), .adv(adv), .oe_n(oe_n),
    .sleep(sleep), .dout_en(dout_en), .cur_op(cur_op), .cur_addr(cur_addr),
    .pend_valid(pend_valid), .pend_addr(pend_addr)
);

// File: tb/zbt_sram_test.sv
`timescale 1ns/100ps
module zbt_sram_test;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic          we_n, ce1_n, ce2, ce3_n, cke_n, adv, lin_mode, oe_n, sleep;
    logic [NL-1:0] bw_n;
    logic [DW-1:0] dout;
    logic          dout_en;

    logic [DW-1:0] shadow [DEPTH];
    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(8)) uut (
        .clk(clk), .rst(rst), .addr(addr), .din(din), .we_n(we_n), .bw_n(bw_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .cke_n(cke_n), .adv(adv),
        .lin_mode(lin_mode), .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic apply_shadow(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NL-1:0] bn);
        for (int i = 0; i < NL; i++)
            if (!bn[i]) shadow[a][i*8 +: 8] = d[i*8 +: 8];
    endtask

    task automatic load(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NL-1:0] bn);
        addr = a; din = d; bw_n = bn; we_n = !wr; adv = 0;
        ce1_n = 0; ce2 = 1; ce3_n = 0;
        tick();
        if (wr) apply_shadow(a, d, bn);
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a);
        load(0, a, '0, '1);
        check(tag, dout, shadow[a]);
        check({tag, " en"}, {31'd0, dout_en}, 32'd1);
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int k, input bit lin);
        logic [1:0] lo;
        lo = lin ? 2'((int'(b[1:0]) + k) % 4) : (b[1:0] ^ 2'(k));
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return 32'((a * 32'h01030507) ^ (s * 32'h9E3779B9) ^ 32'h5A5AA5A5);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        rst = 1; addr = '0; din = '0; we_n = 1; bw_n = '1;
        ce1_n = 1; ce2 = 0; ce3_n = 1; cke_n = 0; adv = 0;
        lin_mode = 0; oe_n = 0; sleep = 0;
        repeat (3) tick();
        rst = 0;
        // R1: reset state
        check("R1 dout_en after reset", {31'd0, dout_en}, 32'd0);
        rd("R1 word zero after reset", 6'd5);
        rd("R1 word zero top", 6'(DEPTH - 1));

        // R3/R5: full sweep writes then reads
        for (int a = 0; a < DEPTH; a++) load(1, 6'(a), pat(a, 1), 4'b0000);
        for (int a = 0; a < DEPTH; a++) rd("R3 sweep read", 6'(a));

        // R4/R5/R6: alternating write/read per lane mask, forwarding
        for (int m = 0; m < 16; m++) begin
            logic [AW-1:0] x, y;
            x = 6'(m * 3 + 1); y = 6'(m * 3 + 2);
            load(1, x, pat(m, 7), 4'(m));
            rd("R4 forward same address", x);
            rd("R6 other read while pending", y);
            rd("R5 masked lanes after reads", x);
            load(1, y, pat(m, 9), 4'(~m));
            rd("R4 read after write turnaround", y);
            rd("R6 committed earlier write", x);
        end

        // R2: each chip select wrong blocks a write; deselect drops dout_en
        for (int c = 0; c < 3; c++) begin
            addr = 6'd10; din = 32'hDEAD0000 + c; we_n = 0; bw_n = '0; adv = 0;
            ce1_n = (c == 0); ce2 = (c != 1); ce3_n = (c == 2);
            tick();
            check("R2 deselect dout_en", {31'd0, dout_en}, 32'd0);
            // R11: advance after deselect stays deselected
            adv = 1; ce1_n = 0; ce2 = 1; ce3_n = 0; we_n = 1;
            tick();
            check("R11 adv after deselect", {31'd0, dout_en}, 32'd0);
            rd("R2 word unchanged", 6'd10);
        end

        // R10: bursts in both orders from every start offset
        for (int lm = 0; lm < 2; lm++) begin
            lin_mode = 1'(lm);
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] b;
                b = 6'(32 + s + lm * 8);
                load(1, b, pat(s, 20 + lm), 4'b0000);
                for (int k = 1; k < 4; k++) begin
                    din = pat(s * 4 + k, 30 + lm); bw_n = 4'(k); adv = 1;
                    tick();
                    apply_shadow(beat_addr(b, k, lm[0]), din, 4'(k));
                end
                load(0, b, '0, '1);
                check("R10 burst beat 0", dout, shadow[b]);
                for (int k = 1; k < 5; k++) begin
                    adv = 1;
                    tick();
                    check("R10 burst read beat", dout, shadow[beat_addr(b, k % 4, lm[0])]);
                end
            end
        end
        lin_mode = 0;

        // R7: clock-enable hold
        rd("R7 setup read", 6'd20);
        cke_n = 1; addr = 6'd21; din = 32'hCAFEF00D; we_n = 0; bw_n = '0; adv = 0;
        tick();
        check("R7 output held", dout, shadow[20]);
        check("R7 enable held", {31'd0, dout_en}, 32'd1);
        cke_n = 0;
        rd("R7 ignored write", 6'd21);
        load(0, 6'd44, '0, '1);
        adv = 1; tick();
        cke_n = 1; tick();
        check("R7 burst position held", dout, shadow[beat_addr(6'd44, 1, 0)]);
        cke_n = 0; tick();
        check("R7 burst resumes", dout, shadow[beat_addr(6'd44, 2, 0)]);

        // R8: asynchronous output enable
        rd("R8 setup read", 6'd30);
        oe_n = 1; #1;
        check("R8 oe off enable", {31'd0, dout_en}, 32'd0);
        check("R8 oe off data", dout, 32'd0);
        oe_n = 0; #1;
        check("R8 oe back", dout, shadow[30]);

        // R9: sleep
        sleep = 1; #1;
        check("R9 sleep enable", {31'd0, dout_en}, 32'd0);
        addr = 6'd31; din = 32'h0BADBEEF; we_n = 0; bw_n = '0; adv = 0;
        tick(); tick();
        sleep = 0; #1;
        check("R9 wake data", dout, shadow[30]);
        check("R9 wake enable", {31'd0, dout_en}, 32'd1);
        rd("R9 contents kept", 6'd31);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule